// File: doc/BRIEF.md
# Masked-Access GPIO Port Controller

This block controls one 32-pin general-purpose I/O port from a simple memory-mapped register bus. Software writes an output latch in four ways: a full write, a set of bits, a clear of bits and an inversion of bits. A direction register turns each pin's output driver on or off. The live pin levels are read back through a two-flop synchronizer. A per-bit access mask guards the latch and the pin readback. A masked bit ignores all four kinds of latch write, and it reads as zero in the pin and latch readback. Drivers can therefore touch a subset of the port without a read-modify-write.

Each pin also feeds an interrupt detector. The detector can work on levels or on edges. In edge mode it catches one chosen edge or both edges. Polarity is set per bit. Edge events stay latched until software writes a one to the matching clear bit. Level events track the synchronized input. A per-bit enable forms the masked status, and one interrupt line is the OR of every masked status bit.

The bus is single-cycle. A write presented with the select high takes effect at the next rising clock edge. Read data is combinational from the current address and state.

Top module: `maskio_port`

## Requirements
- R1: After reset, the pin output values, the output enables and the interrupt line are 0. Reads of every register return 0 while the pins are low.
- R2: A write to offset 0x08 loads the write data into the output latch, but only in bits whose mask bit (offset 0x00) is 0. The output pins always show the latch.
- R3: Writing at offset 0x0C forces to 1, at 0x10 forces to 0, and at 0x14 inverts every latch bit that is written as 1 and is not masked. All other bits keep their value.
- R4: A read of offset 0x04 (pins) or 0x08 (latch) returns 0 in every bit whose mask bit is 1.
- R5: A read of offset 0x04 returns the pin level as sampled two clock edges earlier, whatever the direction setting.
- R6: The output enable of each pin equals the direction register at offset 0x20, where 1 means drive.
- R7: A pin whose sense bit (offset 0x24) is 1 is level-sensitive. Its raw status (read at 0x34) is 1 while the synchronized pin equals its polarity bit (offset 0x2C: 1 means high, 0 means low). A clear write has no effect on it.
- R8: A pin whose sense bit is 0 is edge-sensitive. With its both-edges bit 0, a polarity bit of 1 catches rising edges and 0 catches falling edges. The raw status bit then holds 1 until a 1 is written to that bit at offset 0x3C. A new edge in the same cycle as the clear wins.
- R9: An edge-sensitive pin whose both-edges bit (offset 0x28) is 1 catches both rising and falling edges, and it ignores its polarity bit.
- R10: A read at 0x38 returns the raw status AND the enable register (offset 0x30). The interrupt line is 1 exactly when any of those bits is 1.
- R11: The write-only offsets 0x0C, 0x10, 0x14 and 0x3C read as 0. Writes to the read-only offsets 0x04, 0x34 and 0x38 are ignored. Every other offset, including 0x40, reads 0 and ignores writes.
- R12: The registers at 0x00, 0x20, 0x24, 0x28, 0x2C and 0x30 read back exactly the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access valid this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data (combinational) |
| pinIn | input | 32 | Asynchronous pin levels |
| pinOut | output | 32 | Output latch to the pads |
| pinOe | output | 32 | Per-pin output driver enable |
| irqOut | output | 1 | Combined interrupt |

## Verification
The bench goes after the corner cases below, and each one shows up at an output port.

- **Mask boundaries.** It runs writes of each of the four latch kinds across a partial mask. A design that applied the mask to only some write kinds would move masked output pins. One that forgot the mask on the read path would return latch or pin bits that should read as zero.
- **Synchronizer depth.** It checks the pin readback in the cycles right after a pin changes. A design with one flop too few or too many shows the new level a cycle early or late.
- **Interrupt detection.** It changes detection mode and polarity per bit and then toggles pins. A design that confused rising with falling edges, let a clear drop a level event, or let a clear win over a simultaneous new edge would show the wrong raw status.
- **Random mix.** A long random run of register traffic against live pins lands writes to read-only offsets, writes to reserved offsets and collisions between clears and edges.

// File: rtl/maskio_pkg.sv
package maskio_pkg;

  // Register byte offsets; the software interface depends on these.
  localparam int unsigned OFS_MASK  = 32'h00;
  localparam int unsigned OFS_PIN   = 32'h04;
  localparam int unsigned OFS_OUT   = 32'h08;
  localparam int unsigned OFS_SET   = 32'h0C;
  localparam int unsigned OFS_CLR   = 32'h10;
  localparam int unsigned OFS_INV   = 32'h14;
  localparam int unsigned OFS_DIR   = 32'h20;
  localparam int unsigned OFS_SENSE = 32'h24;
  localparam int unsigned OFS_BOTH  = 32'h28;
  localparam int unsigned OFS_POL   = 32'h2C;
  localparam int unsigned OFS_EN    = 32'h30;
  localparam int unsigned OFS_RAW   = 32'h34;
  localparam int unsigned OFS_MSKD  = 32'h38;
  localparam int unsigned OFS_ACK   = 32'h3C;

  typedef enum logic [3:0] {
    RD_NONE, RD_MASK, RD_PIN, RD_OUT, RD_DIR, RD_SENSE,
    RD_BOTH, RD_POL, RD_EN, RD_RAW, RD_MSKD
  } rdSel_e;

  typedef struct packed {
    logic   wrMask;
    logic   wrOut;
    logic   wrSet;
    logic   wrClr;
    logic   wrInv;
    logic   wrDir;
    logic   wrSense;
    logic   wrBoth;
    logic   wrPol;
    logic   wrEn;
    logic   wrAck;
    rdSel_e rdSel;
  } ctlStrobe_t;

endpackage

// File: rtl/maskio_ctrl.sv
module maskio_ctrl
  import maskio_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output ctlStrobe_t        strobe
);

  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_PIN   = ADDR_W'(OFS_PIN);
  localparam logic [ADDR_W-1:0] A_OUT   = ADDR_W'(OFS_OUT);
  localparam logic [ADDR_W-1:0] A_SET   = ADDR_W'(OFS_SET);
  localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(OFS_CLR);
  localparam logic [ADDR_W-1:0] A_INV   = ADDR_W'(OFS_INV);
  localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'(OFS_DIR);
  localparam logic [ADDR_W-1:0] A_SENSE = ADDR_W'(OFS_SENSE);
  localparam logic [ADDR_W-1:0] A_BOTH  = ADDR_W'(OFS_BOTH);
  localparam logic [ADDR_W-1:0] A_POL   = ADDR_W'(OFS_POL);
  localparam logic [ADDR_W-1:0] A_EN    = ADDR_W'(OFS_EN);
  localparam logic [ADDR_W-1:0] A_RAW   = ADDR_W'(OFS_RAW);
  localparam logic [ADDR_W-1:0] A_MSKD  = ADDR_W'(OFS_MSKD);
  localparam logic [ADDR_W-1:0] A_ACK   = ADDR_W'(OFS_ACK);

  wire doWr = busSel & busWrite;
  wire doRd = busSel & ~busWrite;

  // Decode: one write strobe or one read select per access; unmapped -> none.
  always_comb begin
    strobe       = '0;
    strobe.rdSel = RD_NONE;
    case (busAddr)
      A_MASK: begin
        strobe.wrMask = doWr;
        if (doRd) strobe.rdSel = RD_MASK;
      end
      A_PIN: begin
        if (doRd) strobe.rdSel = RD_PIN;
      end
      A_OUT: begin
        strobe.wrOut = doWr;
        if (doRd) strobe.rdSel = RD_OUT;
      end
      A_SET: strobe.wrSet = doWr;
      A_CLR: strobe.wrClr = doWr;
      A_INV: strobe.wrInv = doWr;
      A_DIR: begin
        strobe.wrDir = doWr;
        if (doRd) strobe.rdSel = RD_DIR;
      end
      A_SENSE: begin
        strobe.wrSense = doWr;
        if (doRd) strobe.rdSel = RD_SENSE;
      end
      A_BOTH: begin
        strobe.wrBoth = doWr;
        if (doRd) strobe.rdSel = RD_BOTH;
      end
      A_POL: begin
        strobe.wrPol = doWr;
        if (doRd) strobe.rdSel = RD_POL;
      end
      A_EN: begin
        strobe.wrEn = doWr;
        if (doRd) strobe.rdSel = RD_EN;
      end
      A_RAW: begin
        if (doRd) strobe.rdSel = RD_RAW;
      end
      A_MSKD: begin
        if (doRd) strobe.rdSel = RD_MSKD;
      end
      A_ACK: strobe.wrAck = doWr;
      default: ;
    endcase
  end

endmodule

// File: rtl/maskio_irq.sv
module maskio_irq #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] syncIn,
  input  logic [WIDTH-1:0] senseCfg,
  input  logic [WIDTH-1:0] bothCfg,
  input  logic [WIDTH-1:0] polCfg,
  input  logic [WIDTH-1:0] ackBits,
  output logic [WIDTH-1:0] rawStat
);

  logic [WIDTH-1:0] prevIn;
  logic [WIDTH-1:0] edgeLatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevIn <= '0;
    else       prevIn <= syncIn;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic riseHit;
    logic fallHit;
    logic edgeHit;
    logic levelHit;
    logic latchQ;

    assign riseHit  = syncIn[i] & ~prevIn[i];
    assign fallHit  = ~syncIn[i] & prevIn[i];
    assign edgeHit  = bothCfg[i] ? (riseHit | fallHit)
                                 : (polCfg[i] ? riseHit : fallHit);
    assign levelHit = polCfg[i] ? syncIn[i] : ~syncIn[i];

    // A fresh edge wins over a clear arriving in the same cycle.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) latchQ <= 1'b0;
      else       latchQ <= (latchQ & ~ackBits[i]) | (edgeHit & ~senseCfg[i]);
    end

    assign edgeLatch[i] = latchQ;
    assign rawStat[i]   = senseCfg[i] ? levelHit : latchQ;
  end

  // R8: a latched edge bit can only drop after a clear of that bit.
  a_r8_edge_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (($past(edgeLatch) & ~$past(ackBits) & ~edgeLatch) == '0));

endmodule

// File: rtl/maskio_dp.sv
module maskio_dp
  import maskio_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobe,
  input  logic [WIDTH-1:0] busWdata,
  output logic [WIDTH-1:0] busRdata,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinOe,
  output logic             irqOut
);

  logic [WIDTH-1:0] accMask;
  logic [WIDTH-1:0] outLatch;
  logic [WIDTH-1:0] dirReg;
  logic [WIDTH-1:0] senseReg;
  logic [WIDTH-1:0] bothReg;
  logic [WIDTH-1:0] polReg;
  logic [WIDTH-1:0] enReg;
  logic [WIDTH-1:0] syncA;
  logic [WIDTH-1:0] syncB;
  logic [WIDTH-1:0] rawStat;
  logic [WIDTH-1:0] mskdStat;
  logic [WIDTH-1:0] openBits;
  logic [WIDTH-1:0] ackBits;

  // Two-flop synchronizer on the pins.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
    end
  end

  assign openBits = busWdata & ~accMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               outLatch <= '0;
    else if (strobe.wrOut)   outLatch <= (outLatch & accMask) | openBits;
    else if (strobe.wrSet)   outLatch <= outLatch | openBits;
    else if (strobe.wrClr)   outLatch <= outLatch & ~openBits;
    else if (strobe.wrInv)   outLatch <= outLatch ^ openBits;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accMask  <= '0;
      dirReg   <= '0;
      senseReg <= '0;
      bothReg  <= '0;
      polReg   <= '0;
      enReg    <= '0;
    end else begin
      if (strobe.wrMask)  accMask  <= busWdata;
      if (strobe.wrDir)   dirReg   <= busWdata;
      if (strobe.wrSense) senseReg <= busWdata;
      if (strobe.wrBoth)  bothReg  <= busWdata;
      if (strobe.wrPol)   polReg   <= busWdata;
      if (strobe.wrEn)    enReg    <= busWdata;
    end
  end

  assign ackBits = strobe.wrAck ? busWdata : '0;

  maskio_irq #(.WIDTH(WIDTH)) u_irq (
    .clk      (clk),
    .rstN     (rstN),
    .syncIn   (syncB),
    .senseCfg (senseReg),
    .bothCfg  (bothReg),
    .polCfg   (polReg),
    .ackBits  (ackBits),
    .rawStat  (rawStat)
  );

  assign mskdStat = rawStat & enReg;
  assign irqOut   = |mskdStat;
  assign pinOut   = outLatch;
  assign pinOe    = dirReg;

  always_comb begin
    case (strobe.rdSel)
      RD_MASK:  busRdata = accMask;
      RD_PIN:   busRdata = syncB & ~accMask;
      RD_OUT:   busRdata = outLatch & ~accMask;
      RD_DIR:   busRdata = dirReg;
      RD_SENSE: busRdata = senseReg;
      RD_BOTH:  busRdata = bothReg;
      RD_POL:   busRdata = polReg;
      RD_EN:    busRdata = enReg;
      RD_RAW:   busRdata = rawStat;
      RD_MSKD:  busRdata = mskdStat;
      default:  busRdata = '0;
    endcase
  end

  // R2: a masked latch bit never moves.
  a_r2_masked_hold: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrOut | strobe.wrSet | strobe.wrClr | strobe.wrInv) |=>
      (((pinOut ^ $past(pinOut)) & $past(accMask)) == '0));

  // R3: every unmasked bit written as 1 to the set offset ends up high.
  a_r3_set_high: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrSet |=>
      ((pinOut & $past(busWdata & ~accMask)) == $past(busWdata & ~accMask)));

  // R4: masked bits read as zero on the pin and latch readback.
  a_r4_masked_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    ((strobe.rdSel == RD_PIN) || (strobe.rdSel == RD_OUT)) |->
      ((busRdata & accMask) == '0));

  // R6: a direction write shows up on the enables one cycle later.
  a_r6_dir_to_oe: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrDir |=> (pinOe == $past(busWdata)));

  // R10: no interrupt while every enable bit is off.
  a_r10_quiet_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (enReg == '0) |-> !irqOut);

endmodule

// File: rtl/maskio_port.sv
module maskio_port
  import maskio_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WIDTH-1:0]  busWdata,
  output logic [WIDTH-1:0]  busRdata,
  input  logic [WIDTH-1:0]  pinIn,
  output logic [WIDTH-1:0]  pinOut,
  output logic [WIDTH-1:0]  pinOe,
  output logic              irqOut
);

  ctlStrobe_t strobe;

  maskio_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strobe   (strobe)
  );

  maskio_dp #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .pinIn    (pinIn),
    .pinOut   (pinOut),
    .pinOe    (pinOe),
    .irqOut   (irqOut)
  );

  // R11: at most one register write strobe per access.
  a_r11_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrMask, strobe.wrOut, strobe.wrSet, strobe.wrClr,
              strobe.wrInv, strobe.wrDir, strobe.wrSense, strobe.wrBoth,
              strobe.wrPol, strobe.wrEn, strobe.wrAck}));

endmodule

// File: tb/maskio_port_bench.sv
module maskio_port_bench;

  localparam int CLK_PERIOD = 10;
  localparam int Q = CLK_PERIOD / 4;

  localparam bit [7:0] AD_MASK = 8'h00, AD_PIN = 8'h04, AD_OUT = 8'h08,
    AD_SET = 8'h0C, AD_CLR = 8'h10, AD_INV = 8'h14, AD_DIR = 8'h20,
    AD_SENSE = 8'h24, AD_BOTH = 8'h28, AD_POL = 8'h2C, AD_EN = 8'h30,
    AD_RAW = 8'h34, AD_MSKD = 8'h38, AD_ACK = 8'h3C, AD_RSV = 8'h40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] pinIn = '0;
  logic [31:0] pinOut;
  logic [31:0] pinOe;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit live = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  maskio_port u_maskio_port (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .irqOut(irqOut)
  );

  // ---------------- behavioural reference ----------------
  bit [31:0] mMask, mOut, mDir, mIs, mIbe, mIev, mIe, mEdge;
  bit [31:0] hist[$];   // [0]=older sample, [1]=synchronized, [2]=newest

  function automatic bit [31:0] mRaw();
    bit [31:0] r;
    for (int i = 0; i < 32; i++)
      r[i] = mIs[i] ? (hist[1][i] == mIev[i]) : mEdge[i];
    return r;
  endfunction

  function automatic bit [31:0] mRead(bit [7:0] a);
    case (a)
      AD_MASK:  return mMask;
      AD_PIN:   return hist[1] & ~mMask;
      AD_OUT:   return mOut & ~mMask;
      AD_DIR:   return mDir;
      AD_SENSE: return mIs;
      AD_BOTH:  return mIbe;
      AD_POL:   return mIev;
      AD_EN:    return mIe;
      AD_RAW:   return mRaw();
      AD_MSKD:  return mRaw() & mIe;
      default:  return 32'h0;
    endcase
  endfunction

  function automatic string tagOf(bit [7:0] a);
    case (a)
      AD_PIN:  return "R5";
      AD_OUT:  return "R4";
      AD_RAW:  return "R7";
      AD_MSKD: return "R10";
      AD_MASK, AD_DIR, AD_SENSE, AD_BOTH, AD_POL, AD_EN: return "R12";
      default: return "R11";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mMask = 0; mOut = 0; mDir = 0; mIs = 0; mIbe = 0; mIev = 0; mIe = 0;
      mEdge = 0;
      hist = {32'h0, 32'h0, 32'h0};
    end else begin
      bit [31:0] open, nEdge;
      bit wr;
      wr = busSel && busWrite;
      open = busWdata & ~mMask;
      nEdge = mEdge;
      for (int i = 0; i < 32; i++) begin
        bit cur, old, hit, ack;
        cur = hist[1][i];
        old = hist[0][i];
        if (mIbe[i])      hit = (cur != old);
        else if (mIev[i]) hit = cur && !old;
        else              hit = !cur && old;
        ack = wr && (busAddr == AD_ACK) && busWdata[i];
        nEdge[i] = (mEdge[i] && !ack) || (hit && !mIs[i]);
      end
      if (wr) begin
        case (busAddr)
          AD_MASK:  mMask = busWdata;
          AD_OUT:   mOut = (mOut & mMask) | open;
          AD_SET:   mOut = mOut | open;
          AD_CLR:   mOut = mOut & ~open;
          AD_INV:   mOut = mOut ^ open;
          AD_DIR:   mDir = busWdata;
          AD_SENSE: mIs = busWdata;
          AD_BOTH:  mIbe = busWdata;
          AD_POL:   mIev = busWdata;
          AD_EN:    mIe = busWdata;
          default: ;
        endcase
      end
      mEdge = nEdge;
      hist.push_back(pinIn);
      void'(hist.pop_front());
    end
  end

  task automatic expectEq(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Compare every output against the reference on each falling edge.
  always @(negedge clk) begin
    if (live && rstN) begin
      expectEq("R2 pinOut", pinOut, mOut);
      expectEq("R6 pinOe", pinOe, mDir);
      expectEq("R10 irqOut", {31'h0, irqOut}, {31'h0, |(mRaw() & mIe)});
      if (busSel && !busWrite)
        expectEq({tagOf(busAddr), " read"}, busRdata, mRead(busAddr));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic busWr(bit [7:0] a, bit [31:0] d);
    @(posedge clk); #(Q);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
  endtask

  task automatic busRd(bit [7:0] a, output logic [31:0] d);
    @(posedge clk); #(Q);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a; busWdata = '0;
    @(negedge clk); #1;
    d = busRdata;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #(Q);
      busSel = 1'b0; busWrite = 1'b0;
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] rd;
    bit [7:0] addrs[15];
    addrs = '{AD_MASK, AD_PIN, AD_OUT, AD_SET, AD_CLR, AD_INV, AD_DIR,
              AD_SENSE, AD_BOTH, AD_POL, AD_EN, AD_RAW, AD_MSKD, AD_ACK, AD_RSV};
    idle(3);
    rstN = 1'b1;
    live = 1'b1;

    // R1: reset state
    expectEq("R1 pinOut", pinOut, 32'h0);
    expectEq("R1 pinOe", pinOe, 32'h0);
    expectEq("R1 irq", {31'h0, irqOut}, 32'h0);
    foreach (addrs[i]) begin
      busRd(addrs[i], rd);
      expectEq("R1 reg", rd, 32'h0);
    end

    // R2: full latch write, no mask
    busWr(AD_OUT, 32'hA5A5_0F0F);
    busRd(AD_OUT, rd);
    expectEq("R2 out", pinOut, 32'hA5A5_0F0F);

    // R12 / R2 / R4: partial mask
    busWr(AD_MASK, 32'hFFFF_0000);
    busWr(AD_OUT, 32'h1234_5678);
    busRd(AD_MASK, rd);
    expectEq("R12 mask", rd, 32'hFFFF_0000);
    expectEq("R2 masked write", pinOut, 32'hA5A5_5678);
    busRd(AD_OUT, rd);
    expectEq("R4 masked read", rd, 32'h0000_5678);

    // R3: set / clear / invert through the mask
    busWr(AD_SET, 32'hFFFF_00F0);
    busRd(AD_OUT, rd);
    expectEq("R3 set", pinOut, 32'hA5A5_56F8);
    busWr(AD_CLR, 32'hFFFF_0F00);
    busRd(AD_OUT, rd);
    expectEq("R3 clear", pinOut, 32'hA5A5_50F8);
    busWr(AD_INV, 32'hFFFF_000F);
    busRd(AD_OUT, rd);
    expectEq("R3 invert", pinOut, 32'hA5A5_50F7);

    // R11: write-only reads zero, read-only and reserved ignore writes
    busRd(AD_SET, rd);
    expectEq("R11 wo read", rd, 32'h0);
    busWr(AD_PIN, 32'hFFFF_FFFF);
    busWr(AD_RSV, 32'hFFFF_FFFF);
    busWr(8'h18, 32'hFFFF_FFFF);
    busRd(AD_RSV, rd);
    expectEq("R11 reserved read", rd, 32'h0);
    expectEq("R11 ignored write", pinOut, 32'hA5A5_50F7);
    busRd(AD_MASK, rd);
    expectEq("R11 mask untouched", rd, 32'hFFFF_0000);

    // R6: direction
    busWr(AD_DIR, 32'h0F0F_F0F0);
    busRd(AD_DIR, rd);
    expectEq("R6 oe", pinOe, 32'h0F0F_F0F0);

    // R5: pin readback latency, independent of direction
    busWr(AD_MASK, 32'h0);
    pinIn = 32'hDEAD_BEEF;
    busRd(AD_PIN, rd);
    expectEq("R5 pin early", rd, 32'h0);
    idle(3);
    busRd(AD_PIN, rd);
    expectEq("R5 pin", rd, 32'hDEAD_BEEF);
    busWr(AD_MASK, 32'h0000_FFFF);
    busRd(AD_PIN, rd);
    expectEq("R4 pin masked", rd, 32'hDEAD_0000);
    busWr(AD_MASK, 32'h0);

    // R8 / R9: edge detection
    busWr(AD_POL, 32'h0000_0001);
    busWr(AD_BOTH, 32'h0000_0004);
    busWr(AD_EN, 32'h0000_0007);
    pinIn = 32'h0;
    idle(4);
    busWr(AD_ACK, 32'hFFFF_FFFF);
    idle(1);
    busRd(AD_RAW, rd);
    expectEq("R8 cleared", rd, 32'h0);
    pinIn = 32'h7;
    idle(4);
    busRd(AD_RAW, rd);
    expectEq("R8 R9 rising", rd, 32'h5);
    expectEq("R10 irq on", {31'h0, irqOut}, 32'h1);
    pinIn = 32'h0;
    idle(4);
    busRd(AD_RAW, rd);
    expectEq("R8 R9 falling", rd, 32'h7);
    busWr(AD_ACK, 32'h1);
    busRd(AD_RAW, rd);
    expectEq("R8 clear one", rd, 32'h6);
    busWr(AD_EN, 32'h1);
    busRd(AD_MSKD, rd);
    expectEq("R10 masked", rd, 32'h0);
    expectEq("R10 irq off", {31'h0, irqOut}, 32'h0);

    // R7: level mode
    busWr(AD_SENSE, 32'h0000_000F);
    busWr(AD_POL, 32'h0000_0005);
    busWr(AD_EN, 32'h0000_000F);
    idle(2);
    busRd(AD_RAW, rd);
    expectEq("R7 level low", rd, 32'hA);
    pinIn = 32'h3;
    idle(3);
    busRd(AD_RAW, rd);
    expectEq("R7 level mixed", rd, 32'h9);
    busWr(AD_ACK, 32'hFFFF_FFFF);
    busRd(AD_RAW, rd);
    expectEq("R7 clear no effect", rd, 32'h9);

    // Random mix against the reference (all requirements)
    for (int n = 0; n < 2000; n++) begin
      int pick;
      pick = $urandom_range(0, 14);
      if ($urandom_range(0, 3) == 0) pinIn = $urandom();
      if ($urandom_range(0, 1) == 0) busWr(addrs[pick], $urandom());
      else busRd(addrs[pick], rd);
    end
    idle(2);
    finishRun();
  end

endmodule